// File: doc/BRIEF.md
# Multi-Channel Block-Move DMA Engine

This block moves contiguous runs of 32-bit words on behalf of several independent channels. Software fills a channel's register window with a source address, a destination address, a stepping mode for each side and a byte count, then writes a channel bitmask into one shared command word. Each started channel then copies one word per beat, reading the source and writing the destination, until its byte count runs out. A bit in the same command word turns the mask into an abort request.

All channels share one word-wide memory port. Requests use valid/ready. Once `mem_req_valid` is high, the request fields hold steady until `mem_req_ready` is sampled high. Only one access is outstanding at a time. A read is answered later by a single-cycle `mem_rsp_valid` carrying the data. Channels that need the port are served one beat at a time in round-robin order. Each channel pulses `done_evt` when it finishes or is aborted, and also pulses `abort_evt` when it is aborted. An interrupt block can latch these pulses. Reading the count register returns the bytes still left while the channel runs.

Top module: `dma_multi`

## Requirements
- R1: A write to address 0x000 with bit 31 clear starts every idle channel whose bit is 1 (bit position = channel number); that channel's `busy` rises on the next cycle.
- R2: A write to 0x000 with bit 31 set aborts every busy channel in the mask. On the next cycle `busy` is low and `abort_evt` and `done_evt` pulse together for one cycle. The count keeps its residue. Aborting an idle channel produces no event.
- R3: Channel n's window starts at 0x100 + n*0x40. Within it: source mode at 0x20, destination mode at 0x24, source address at 0x28, destination address at 0x2C, byte count at 0x30. All of them read back.
- R4: A mode value sits in bits [5:4] and reads back there. 0 steps the address up by 4 per beat, 1 steps it down by 4, and 2 (or 3) holds it fixed.
- R5: Each beat reads the word at the source address and writes it to the destination address. The count then drops by 4, going to 0 if it was below 4, so a partial final word still moves a whole word. Reading the count during a run returns the live residue.
- R6: When the count of a busy channel is 0, the channel goes idle and pulses `done_evt` (without `abort_evt`) on the next cycle. A start with count 0 finishes this way with no memory access.
- R7: A start aimed at a busy channel, and register writes to a busy channel's window, have no effect.
- R8: Requesting channels receive memory beats in round-robin order, one beat per grant.
- R9: A request held without ready keeps valid, address, write flag and write data unchanged.
- R10: An abort that lands while a beat's read is still pending suppresses that beat's write. An abort in the same cycle as the final write's acceptance wins: one `abort_evt`/`done_evt` pulse, and the count keeps its pre-beat value.
- R11: After reset every channel is idle, all registers read 0, no event is pending and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | NCH | Channel running |
| done_evt | output | NCH | One-cycle finish pulse (also on abort) |
| abort_evt | output | NCH | One-cycle abort pulse |

## Verification
The sharpest overlap is an abort command arriving in the very cycle the memory accepts a channel's final write, so completion and abort compete for the same channel edge. The bench stalls `mem_req_ready` once the write is presented, then raises ready and issues the abort command in one cycle. It expects exactly one pulse of `abort_evt` and `done_evt`, no second done one cycle later, the write counted once, and the count reading 4. A second overlap starts three channels with one command word, which forces the arbiter to share the port. There the bench checks that the write order repeats the same three-channel rotation.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned BEAT_BYTES  = 4;
  localparam int unsigned ABORT_BIT   = 31;
  localparam int unsigned WIN_BASE    = 'h100;
  localparam int unsigned WIN_SHIFT   = 6;
  localparam logic [5:0]  OFS_SMODE   = 6'h20;
  localparam logic [5:0]  OFS_DMODE   = 6'h24;
  localparam logic [5:0]  OFS_SADDR   = 6'h28;
  localparam logic [5:0]  OFS_DADDR   = 6'h2C;
  localparam logic [5:0]  OFS_COUNT   = 6'h30;

  typedef enum logic [1:0] {STEP_UP = 2'd0, STEP_DOWN = 2'd1, STEP_HOLD = 2'd2, STEP_HOLD_ALT = 2'd3} step_e;
  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WAIT, MV_WRITE} mv_state_e;

  typedef struct packed {
    logic smode;
    logic dmode;
    logic saddr;
    logic daddr;
    logic count;
  } fld_t;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input logic [1:0] m);
    case (step_e'(m))
      STEP_UP:   return a + ADDR_W'(BEAT_BYTES);
      STEP_DOWN: return a - ADDR_W'(BEAT_BYTES);
      default:   return a;
    endcase
  endfunction
endpackage

// File: rtl/dma_regdec.sv
module dma_regdec
  import dma_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned REG_AW = 12
) (
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    start_vec,
  output logic [NCH-1:0]    abort_vec,
  output logic [NCH-1:0]    win_we,
  output fld_t              fld,
  input  logic [1:0]        smode_a [NCH],
  input  logic [1:0]        dmode_a [NCH],
  input  logic [31:0]       saddr_a [NCH],
  input  logic [31:0]       daddr_a [NCH],
  input  logic [31:0]       count_a [NCH]
);
  localparam int unsigned NW = REG_AW - WIN_SHIFT;
  localparam logic [REG_AW-1:0] WB = REG_AW'(WIN_BASE);

  logic [REG_AW-1:0] rel;
  logic [NW-1:0]     win_num;
  logic [5:0]        ofs;
  logic              in_win;
  logic              cmd_wr;

  assign rel     = reg_addr - WB;
  assign win_num = rel[REG_AW-1:WIN_SHIFT];
  assign ofs     = rel[5:0];
  assign in_win  = (reg_addr >= WB) && (int'(win_num) < NCH);
  assign cmd_wr  = reg_we && (reg_addr == '0);

  assign start_vec = (cmd_wr && !reg_wdata[ABORT_BIT]) ? reg_wdata[NCH-1:0] : '0;
  assign abort_vec = (cmd_wr &&  reg_wdata[ABORT_BIT]) ? reg_wdata[NCH-1:0] : '0;

  assign fld.smode = (ofs == OFS_SMODE);
  assign fld.dmode = (ofs == OFS_DMODE);
  assign fld.saddr = (ofs == OFS_SADDR);
  assign fld.daddr = (ofs == OFS_DADDR);
  assign fld.count = (ofs == OFS_COUNT);

  always_comb begin
    win_we    = '0;
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (in_win && int'(win_num) == i) begin
        win_we[i] = reg_we;
        case (ofs)
          OFS_SMODE: reg_rdata = {26'd0, smode_a[i], 4'd0};
          OFS_DMODE: reg_rdata = {26'd0, dmode_a[i], 4'd0};
          OFS_SADDR: reg_rdata = saddr_a[i];
          OFS_DADDR: reg_rdata = daddr_a[i];
          OFS_COUNT: reg_rdata = count_a[i];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_we,
  input  fld_t        fld,
  input  logic [31:0] wdata,
  input  logic        start,
  input  logic        abort,
  input  logic        beat_done,
  output logic        busy,
  output logic        req,
  output logic        done_evt,
  output logic        abort_evt,
  output logic [1:0]  smode,
  output logic [1:0]  dmode,
  output logic [31:0] saddr,
  output logic [31:0] daddr,
  output logic [31:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_evt  <= 1'b0;
      abort_evt <= 1'b0;
      smode     <= '0;
      dmode     <= '0;
      saddr     <= '0;
      daddr     <= '0;
      count     <= '0;
    end else begin
      done_evt  <= 1'b0;
      abort_evt <= 1'b0;
      if (busy) begin
        if (abort) begin
          busy      <= 1'b0;
          done_evt  <= 1'b1;
          abort_evt <= 1'b1;
        end else if (count == '0) begin
          busy     <= 1'b0;
          done_evt <= 1'b1;
        end else if (beat_done) begin
          saddr <= step_addr(saddr, smode);
          daddr <= step_addr(daddr, dmode);
          count <= (count < 32'(BEAT_BYTES)) ? '0 : count - 32'(BEAT_BYTES);
        end
      end else if (start) begin
        busy <= 1'b1;
      end else if (win_we) begin
        if (fld.smode) smode <= wdata[5:4];
        if (fld.dmode) dmode <= wdata[5:4];
        if (fld.saddr) saddr <= wdata;
        if (fld.daddr) daddr <= wdata;
        if (fld.count) count <= wdata;
      end
    end
  end

  assign req = busy && (count != '0);
endmodule

// File: rtl/dma_rr.sv
module dma_rr #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            take,
  output logic            gnt_any,
  output logic [CH_W-1:0] gnt_idx
);
  logic [CH_W-1:0] last;

  always_comb begin
    int c;
    gnt_any = 1'b0;
    gnt_idx = last;
    for (int k = 1; k <= NCH; k++) begin
      c = (int'(last) + k) % NCH;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last <= CH_W'(NCH - 1);
    else if (take) last <= gnt_idx;
  end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_any,
  input  logic [CH_W-1:0] gnt_idx,
  output logic            take,
  input  logic [NCH-1:0]  abort_vec,
  input  logic [31:0]     saddr_a [NCH],
  input  logic [31:0]     daddr_a [NCH],
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [31:0]     mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic [NCH-1:0]  beat_vec
);
  mv_state_e       state;
  logic [CH_W-1:0] cur;
  logic [31:0]     data_q;
  logic            killed;
  logic            hit;

  assign hit  = abort_vec[cur];
  assign take = (state == MV_IDLE) && gnt_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      cur    <= '0;
      data_q <= '0;
      killed <= 1'b0;
    end else begin
      case (state)
        MV_IDLE: if (gnt_any) begin
          cur    <= gnt_idx;
          killed <= 1'b0;
          state  <= MV_READ;
        end
        MV_READ: begin
          if (hit) killed <= 1'b1;
          if (mem_req_ready) state <= MV_WAIT;
        end
        MV_WAIT: begin
          if (hit) killed <= 1'b1;
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= (killed || hit) ? MV_IDLE : MV_WRITE;
          end
        end
        MV_WRITE: begin
          if (hit) killed <= 1'b1;
          if (mem_req_ready) state <= MV_IDLE;
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == MV_READ) || (state == MV_WRITE);
  assign mem_req_we    = (state == MV_WRITE);
  assign mem_req_addr  = (state == MV_WRITE) ? daddr_a[cur] : saddr_a[cur];
  assign mem_req_wdata = data_q;

  always_comb begin
    beat_vec = '0;
    if (state == MV_WRITE && mem_req_ready && !killed && !hit) beat_vec[cur] = 1'b1;
  end
endmodule

// File: rtl/dma_multi.sv
module dma_multi
  import dma_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned REG_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    done_evt,
  output logic [NCH-1:0]    abort_evt
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]  start_vec, abort_vec, win_we, req_w, req_ok, beat_vec;
  fld_t            fld;
  logic [1:0]      smode_a [NCH];
  logic [1:0]      dmode_a [NCH];
  logic [31:0]     saddr_a [NCH];
  logic [31:0]     daddr_a [NCH];
  logic [31:0]     count_a [NCH];
  logic            gnt_any, take;
  logic [CH_W-1:0] gnt_idx;

  dma_regdec #(.NCH(NCH), .REG_AW(REG_AW)) u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_vec(start_vec), .abort_vec(abort_vec), .win_we(win_we), .fld(fld),
    .smode_a(smode_a), .dmode_a(dmode_a), .saddr_a(saddr_a), .daddr_a(daddr_a), .count_a(count_a)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan u_chan (
      .clk(clk), .rst_n(rst_n), .win_we(win_we[g]), .fld(fld), .wdata(reg_wdata),
      .start(start_vec[g]), .abort(abort_vec[g]), .beat_done(beat_vec[g]),
      .busy(busy[g]), .req(req_w[g]), .done_evt(done_evt[g]), .abort_evt(abort_evt[g]),
      .smode(smode_a[g]), .dmode(dmode_a[g]), .saddr(saddr_a[g]), .daddr(daddr_a[g]),
      .count(count_a[g])
    );
  end

  assign req_ok = req_w & ~abort_vec;

  dma_rr #(.NCH(NCH), .CH_W(CH_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .req(req_ok), .take(take), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  dma_mover #(.NCH(NCH), .CH_W(CH_W)) u_mv (
    .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx), .take(take),
    .abort_vec(abort_vec), .saddr_a(saddr_a), .daddr_a(daddr_a),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .beat_vec(beat_vec)
  );
endmodule

// File: rtl/dma_multi_chk.sv
module dma_multi_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] start_vec,
  input logic [NCH-1:0] abort_vec,
  input logic [NCH-1:0] beat_vec,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] done_evt,
  input logic [NCH-1:0] abort_evt,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_we,
  input logic [31:0]    mem_req_addr,
  input logic [31:0]    mem_req_wdata
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_vec[g] && !busy[g]) |=> busy[g]);
    assert_abort_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_vec[g] && busy[g]) |=> (!busy[g] && abort_evt[g] && done_evt[g]));
    assert_idle_abort_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_vec[g] && !busy[g]) |=> !abort_evt[g]);
    assert_abort_has_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt[g] |-> done_evt[g]);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt[g] |-> !busy[g]);
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  assert_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(beat_vec));
endmodule

bind dma_multi dma_multi_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_vec(start_vec), .abort_vec(abort_vec), .beat_vec(beat_vec),
  .busy(busy), .done_evt(done_evt), .abort_evt(abort_evt),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_dma_multi.sv
module test_dma_multi;
  localparam int NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_we, mem_rdy = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [NCH-1:0] busy, done_evt, abort_evt;

  int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0, wlog_n = 0;
  logic [31:0] mem [256];
  logic [31:0] expm [256];
  logic [7:0]  wlog [16];

  always #5 clk = ~clk;

  dma_multi #(.NCH(NCH), .REG_AW(12)) i_dma_multi (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done_evt(done_evt), .abort_evt(abort_evt)
  );

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_rdy) begin
      if (mem_req_we) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
        if (wlog_n < 16) wlog[wlog_n] <= mem_req_addr[9:2];
        wlog_n <= wlog_n + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [11:0] wa(input int ch, input logic [11:0] o);
    return 12'h100 + 12'(ch) * 12'h40 + o;
  endfunction

  task automatic prog(input int ch, input logic [1:0] sm, input logic [1:0] dm,
                      input logic [31:0] sa, input logic [31:0] da, input logic [31:0] n);
    wr(wa(ch, 12'h20), {26'd0, sm, 4'd0});
    wr(wa(ch, 12'h24), {26'd0, dm, 4'd0});
    wr(wa(ch, 12'h28), sa);
    wr(wa(ch, 12'h2C), da);
    wr(wa(ch, 12'h30), n);
  endtask

  task automatic wait_done(input int ch, output bit seen, output bit ab);
    seen = 0; ab = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (done_evt[ch]) begin seen = 1; ab = abort_evt[ch]; end
    end
  endtask

  function automatic logic [31:0] stp(input logic [31:0] a, input logic [1:0] m);
    return (m == 2'd0) ? a + 1 : (m == 2'd1) ? a - 1 : a;
  endfunction

  // ch[29:28] smode[27:26] dmode[25:24] src word[23:16] dst word[15:8] bytes[7:0]
  localparam logic [29:0] VEC [6] = '{
    {2'd0, 2'd0, 2'd0, 8'h10, 8'h80, 8'd16},
    {2'd1, 2'd1, 2'd0, 8'h20, 8'h90, 8'd12},
    {2'd2, 2'd0, 2'd2, 8'h30, 8'hA0, 8'd20},
    {2'd3, 2'd2, 2'd1, 8'h40, 8'hB8, 8'd8},
    {2'd1, 2'd0, 2'd1, 8'h50, 8'hC0, 8'd6},
    {2'd0, 2'd0, 2'd0, 8'h60, 8'hD0, 8'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    bit seen, ab;
    int r0, w0, nseen;
    logic [31:0] seq [8];
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 valid", 32'(mem_req_valid), 32'd0);
    chk("R11 events", 32'(done_evt | abort_evt), 32'd0);
    rd(wa(1, 12'h30), d); chk("R11 count", d, 32'd0);

    // R3 / R4 window map and mode readback
    wr(wa(2, 12'h20), 32'h0000_0020);
    rd(wa(2, 12'h20), d); chk("R3 R4 smode readback", d, 32'h20);
    wr(wa(3, 12'h2C), 32'h1234_5678);
    rd(wa(3, 12'h2C), d); chk("R3 daddr readback", d, 32'h1234_5678);
    rd(wa(2, 12'h2C), d); chk("R3 neighbour window untouched", d, 32'd0);

    // vector table: R1 R4 R5 R6
    mem_rdy = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int ch, beats;
      logic [1:0] sm, dm;
      logic [31:0] s, t, n;
      ch = int'(VEC[v][29:28]); sm = VEC[v][27:26]; dm = VEC[v][25:24];
      s = 32'(VEC[v][23:16]); t = 32'(VEC[v][15:8]); n = 32'(VEC[v][7:0]);
      for (int i = 0; i < 256; i++) begin mem[i] = 32'hC0DE_0000 | 32'(i); expm[i] = mem[i]; end
      beats = (int'(n) + 3) / 4;
      prog(ch, sm, dm, s * 4, t * 4, n);
      r0 = rd_cnt;
      wr(12'h000, 32'(1) << ch);
      chk("R1 busy after start", 32'(busy[ch] | done_evt[ch]), 32'd1);
      wait_done(ch, seen, ab);
      chk("R6 done seen", 32'(seen), 32'd1);
      chk("R6 no abort on finish", 32'(ab), 32'd0);
      chk("R5 R6 read count", 32'(rd_cnt - r0), 32'(beats));
      for (int k = 0; k < beats; k++) begin
        expm[t[7:0]] = expm[s[7:0]];
        s = stp(s, sm); t = stp(t, dm);
      end
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
        chk("R4 R5 memory image mismatches", 32'(bad), 32'd0);
      end
      rd(wa(ch, 12'h30), d); chk("R5 count empty", d, 32'd0);
      rd(wa(ch, 12'h28), d); chk("R4 final saddr", d, s * 4);
      rd(wa(ch, 12'h2C), d); chk("R4 final daddr", d, t * 4);
    end

    // R5 live residue
    prog(0, 2'd0, 2'd0, 32'h40, 32'h200, 32'd16);
    wr(12'h000, 32'h1);
    rd(wa(0, 12'h30), prev); chk("R5 residue start", prev, 32'd16);
    nseen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      rd(wa(0, 12'h30), d);
      if (d != prev && nseen < 8) begin seq[nseen] = d; nseen++; prev = d; end
    end
    chk("R5 residue steps", 32'(nseen), 32'd4);
    chk("R5 residue 12", seq[0], 32'd12);
    chk("R5 residue 4", seq[2], 32'd4);

    // R9 back-pressure, R7 ignored while busy
    mem_rdy = 1'b0;
    prog(0, 2'd0, 2'd0, 32'h40, 32'h200, 32'd16);
    wr(12'h000, 32'h1);
    repeat (2) @(negedge clk);
    chk("R9 valid held", {31'd0, mem_req_valid}, 32'd1);
    chk("R9 read address", mem_req_addr, 32'h40);
    @(negedge clk);
    chk("R9 address stable", mem_req_addr, 32'h40);
    wr(12'h000, 32'h1);
    wr(wa(0, 12'h30), 32'd100);
    rd(wa(0, 12'h30), d); chk("R7 count write ignored", d, 32'd16);
    chk("R7 still busy", 32'(busy[0]), 32'd1);

    // R2 abort while read pending, R10 write suppressed
    w0 = wr_cnt;
    wr(12'h000, 32'h8000_0001);
    chk("R2 abort_evt", 32'(abort_evt[0]), 32'd1);
    chk("R2 done_evt on abort", 32'(done_evt[0]), 32'd1);
    chk("R2 idle after abort", 32'(busy[0]), 32'd0);
    rd(wa(0, 12'h30), d); chk("R2 residue kept", d, 32'd16);
    mem_rdy = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 no write after abort", 32'(wr_cnt - w0), 32'd0);

    // R2 abort of idle channel
    wr(12'h000, 32'h8000_0004);
    chk("R2 idle abort quiet", 32'(abort_evt | done_evt), 32'd0);

    // R8 round robin
    prog(0, 2'd0, 2'd0, 32'h40, 32'h200, 32'd8);
    prog(1, 2'd0, 2'd0, 32'h80, 32'h240, 32'd8);
    prog(2, 2'd0, 2'd0, 32'hC0, 32'h280, 32'd8);
    @(negedge clk); wlog_n = 0;
    wr(12'h000, 32'h7);
    for (int k = 0; k < 100 && busy != '0; k++) @(negedge clk);
    chk("R8 write count", 32'(wlog_n), 32'd6);
    chk("R8 distinct first round", 32'((wlog[0] != wlog[1]) && (wlog[1] != wlog[2]) && (wlog[0] != wlog[2])), 32'd1);
    for (int k = 0; k < 3; k++) chk("R8 same rotation", 32'(wlog[k + 3]), 32'(wlog[k] + 8'd1));

    // R10 abort on same cycle as final write acceptance
    mem_rdy = 1'b0;
    prog(3, 2'd0, 2'd0, 32'h10, 32'h300, 32'd4);
    wr(12'h000, 32'h8);
    for (int k = 0; k < 20 && !(mem_req_valid && !mem_req_we); k++) @(negedge clk);
    mem_rdy = 1'b1;
    @(negedge clk); mem_rdy = 1'b0;
    for (int k = 0; k < 20 && !(mem_req_valid && mem_req_we); k++) @(negedge clk);
    w0 = wr_cnt;
    mem_rdy = 1'b1; reg_we = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h8000_0008;
    @(negedge clk);
    reg_we = 1'b0; mem_rdy = 1'b0;
    chk("R10 abort_evt", 32'(abort_evt[3]), 32'd1);
    chk("R10 done_evt", 32'(done_evt[3]), 32'd1);
    chk("R10 write happened", 32'(wr_cnt - w0), 32'd1);
    rd(wa(3, 12'h30), d); chk("R10 count pre-beat", d, 32'd4);
    @(negedge clk);
    chk("R10 single done", 32'(done_evt[3]), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule